// File: doc/BRIEF.md
# UART DMA Request Pin Generator

This block drives the two active-low DMA request outputs of one UART channel: one asking for transmit data and one offering received data. It does not hold the FIFOs. It watches the transmit occupancy (FIFO or holding register), the receive occupancy, the FIFO enable bit, a DMA mode bit, a 2-bit receive trigger select and a receive timeout flag. From these it computes the two request levels, and each output is registered.

Two signalling schemes are supported. Single-character mode asks for service one character at a time. Block mode asks for a burst: transmit stays ready until the FIFO is completely full, and receive asserts at a programmable fill level or on a timeout, then holds until the FIFO has been drained. With the FIFOs disabled, the block always uses the single-character rules, whatever the mode bit says.

Top module: `uart_dma_req`

## Requirements
- R1: Synchronous active-high `rst` drives `tx_req_n` low and `rx_req_n` high on the next clock edge. Outside reset, both outputs take the value implied by the inputs sampled at the previous rising edge, so they lag the inputs by one cycle.
- R2: In single-character mode (`dma_mode` = 0) with the FIFOs enabled, `tx_req_n` is low exactly when `tx_fill` is 0 and high otherwise.
- R3: In block mode (`dma_mode` = 1) with the FIFOs enabled, `tx_req_n` is high only when `tx_fill` equals the FIFO depth (16). It is low at any smaller fill.
- R4: When `fifo_en` = 0, `dma_mode` has no effect and both outputs follow the single-character rules of R2 and R5.
- R5: In single-character mode, or with the FIFOs disabled, `rx_req_n` is low exactly when `rx_fill` is nonzero.
- R6: In block mode with the FIFOs enabled, `rx_req_n` goes low once `rx_fill` reaches the trigger level. The trigger select encodes the level as 00 = 1, 01 = 4, 10 = 8, 11 = 14 characters.
- R7: In block mode with the FIFOs enabled, `rx_timeout` = 1 while `rx_fill` is nonzero drives `rx_req_n` low even below the trigger level. A timeout with an empty receive FIFO leaves `rx_req_n` high.
- R8: In block mode, once `rx_req_n` is low it stays low while `rx_fill` is nonzero, and it returns high only when `rx_fill` is 0. While inactive it stays high while the fill is below the trigger and no timeout is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO enable; 0 selects single-register operation |
| dma_mode | input | 1 | 0 = single-character mode, 1 = block mode |
| tx_fill | input | 5 | Characters held in the transmit FIFO or holding register (0..16) |
| rx_fill | input | 5 | Characters held in the receive FIFO or holding register (0..16) |
| rx_trig_sel | input | 2 | Receive trigger select (00=1, 01=4, 10=8, 11=14) |
| rx_timeout | input | 1 | Receive timeout indication |
| tx_req_n | output | 1 | Transmit DMA request, active low |
| rx_req_n | output | 1 | Receive DMA request, active low |

## Verification
The bench probes the transmit threshold in block mode at 15 and 16 entries. A design that used the single-character rule there would drop the request after the first character. Each trigger select is tested one below and exactly at its level, which catches swapped encodings and off-by-one compares. The receive hysteresis is tested by draining below the trigger without emptying, then by refilling below the trigger; a design without memory would release early or assert early. A timeout is applied both with data present and with an empty FIFO, and the FIFOs are disabled while block mode is selected, to expose a mode bit that is not masked.

// File: rtl/uart_dma_req_pkg.sv
package uart_dma_req_pkg;

    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_BLOCK  = 1'b1
    } dma_mode_e;

    typedef struct packed {
        logic      fifo_en;
        dma_mode_e mode;
    } dma_cfg_t;

    // Block-mode rules apply only with FIFOs on and block mode selected
    function automatic logic block_rules(input dma_cfg_t cfg);
        return cfg.fifo_en && (cfg.mode == DMA_BLOCK);
    endfunction

    // Receive trigger level for a 2-bit select
    function automatic int unsigned rx_trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
    import uart_dma_req_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk,
    input  logic [CW-1:0] fill,
    output logic          req_n
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic req_n_nxt;

    always_comb begin
        if (blk) req_n_nxt = (fill == FULL);
        else     req_n_nxt = (fill != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) req_n <= 1'b0;
        else     req_n <= req_n_nxt;
    end

    AST_TX_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
        (!blk && fill == '0) |=> !req_n); // R2

    AST_TX_SINGLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!blk && fill != '0) |=> req_n); // R2

    AST_TX_BLOCK_FULL: assert property (@(posedge clk) disable iff (rst)
        (blk && fill == FULL) |=> req_n); // R3

    AST_TX_BLOCK_ROOM: assert property (@(posedge clk) disable iff (rst)
        (blk && fill < FULL) |=> !req_n); // R3

endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
    import uart_dma_req_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk,
    input  logic [CW-1:0] fill,
    input  logic [1:0]    trig_sel,
    input  logic          timeout,
    output logic          req_n
);

    logic [CW-1:0] level;
    logic          reached;
    logic          req_n_nxt;

    assign level   = CW'(rx_trig_level(trig_sel));
    assign reached = (fill >= level);

    always_comb begin
        if (fill == '0)              req_n_nxt = 1'b1;
        else if (!blk)               req_n_nxt = 1'b0;
        else if (reached || timeout) req_n_nxt = 1'b0;
        else                         req_n_nxt = req_n;
    end

    always_ff @(posedge clk) begin
        if (rst) req_n <= 1'b1;
        else     req_n <= req_n_nxt;
    end

    AST_RX_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |=> req_n); // R8

    AST_RX_SINGLE_DATA: assert property (@(posedge clk) disable iff (rst)
        (!blk && fill != '0) |=> !req_n); // R5

    AST_RX_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (blk && fill != '0 && fill >= level) |=> !req_n); // R6

    AST_RX_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (blk && fill != '0 && timeout) |=> !req_n); // R7

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (blk && fill != '0 && fill < level && !timeout) |=> $stable(req_n)); // R8

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import uart_dma_req_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          dma_mode,
    input  logic [CW-1:0] tx_fill,
    input  logic [CW-1:0] rx_fill,
    input  logic [1:0]    rx_trig_sel,
    input  logic          rx_timeout,
    output logic          tx_req_n,
    output logic          rx_req_n
);

    dma_cfg_t cfg;
    logic     blk;

    assign cfg.fifo_en = fifo_en;
    assign cfg.mode    = dma_mode_e'(dma_mode);
    assign blk         = block_rules(cfg);

    uart_dma_tx_req #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .blk   (blk),
        .fill  (tx_fill),
        .req_n (tx_req_n)
    );

    uart_dma_rx_req #(.DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .blk      (blk),
        .fill     (rx_fill),
        .trig_sel (rx_trig_sel),
        .timeout  (rx_timeout),
        .req_n    (rx_req_n)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!tx_req_n && rx_req_n)); // R1

    AST_DISABLED_TX: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && tx_fill != '0) |=> tx_req_n); // R4

endmodule

// File: tb/uart_dma_req_test.sv
`timescale 1ns/100ps
module uart_dma_req_test;

    typedef struct {
        logic  exp_tx;
        logic  exp_rx;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en;
    logic       dma_mode;
    logic [4:0] tx_fill;
    logic [4:0] rx_fill;
    logic [1:0] rx_trig_sel;
    logic       rx_timeout;
    logic       tx_req_n;
    logic       rx_req_n;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    uart_dma_req uut (
        .clk         (clk),
        .rst         (rst),
        .fifo_en     (fifo_en),
        .dma_mode    (dma_mode),
        .tx_fill     (tx_fill),
        .rx_fill     (rx_fill),
        .rx_trig_sel (rx_trig_sel),
        .rx_timeout  (rx_timeout),
        .tx_req_n    (tx_req_n),
        .rx_req_n    (rx_req_n)
    );

    // Driver: apply one input set at a falling edge, queue the expected outputs
    task automatic step(input logic r, input logic f, input logic m,
                        input logic [4:0] t, input logic [4:0] x,
                        input logic [1:0] s, input logic to,
                        input logic et, input logic er, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; fifo_en = f; dma_mode = m; tx_fill = t; rx_fill = x;
        rx_trig_sel = s; rx_timeout = to;
        e.exp_tx = et; e.exp_rx = er; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare one cycle after each applied set
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (tx_req_n !== e.exp_tx || rx_req_n !== e.exp_rx) begin
                    errors++;
                    $display("FAIL %s: actual tx=%b rx=%b expected tx=%b rx=%b",
                             e.tag, tx_req_n, rx_req_n, e.exp_tx, e.exp_rx);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fifo_en = 1'b1; dma_mode = 1'b0; tx_fill = 5'd3;
        rx_fill = 5'd3; rx_trig_sel = 2'b00; rx_timeout = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (tx_req_n !== 1'b0 || rx_req_n !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: actual tx=%b rx=%b expected tx=0 rx=1",
                     tx_req_n, rx_req_n);
        end

        // single-character mode, FIFOs on
        step(0,1,0, 5'd0, 5'd0, 2'b00,0, 0,1, "R2 R5 empty");
        step(0,1,0, 5'd1, 5'd0, 2'b00,0, 1,1, "R2 one tx char");
        step(0,1,0,5'd16, 5'd3, 2'b11,0, 1,0, "R2 R5 data both sides");
        step(0,1,0, 5'd0, 5'd1, 2'b11,0, 0,0, "R5 one rx char below trigger");
        // FIFOs disabled: mode bit ignored
        step(0,0,0, 5'd0, 5'd1, 2'b00,0, 0,0, "R4 R5 holding register");
        step(0,0,1, 5'd1, 5'd0, 2'b10,0, 1,1, "R4 block bit ignored tx");
        step(0,0,1, 5'd0, 5'd1, 2'b11,0, 0,0, "R4 block bit ignored rx");
        // mid-run reset
        step(1,1,0, 5'd5, 5'd5, 2'b00,0, 0,1, "R1 reset with data");
        // block mode, trigger 8
        step(0,1,1, 5'd0, 5'd0, 2'b10,0, 0,1, "R3 R8 block empty");
        step(0,1,1,5'd15, 5'd0, 2'b10,0, 0,1, "R3 one slot free");
        step(0,1,1,5'd16, 5'd0, 2'b10,0, 1,1, "R3 tx full");
        step(0,1,1,5'd15, 5'd7, 2'b10,0, 0,1, "R6 below trigger 8");
        step(0,1,1,5'd15, 5'd8, 2'b10,0, 0,0, "R6 at trigger 8");
        step(0,1,1,5'd15, 5'd3, 2'b10,0, 0,0, "R8 hold while draining");
        step(0,1,1, 5'd0, 5'd0, 2'b10,0, 0,1, "R8 release on empty");
        step(0,1,1, 5'd0, 5'd3, 2'b10,0, 0,1, "R8 stay idle below trigger");
        step(0,1,1, 5'd0, 5'd3, 2'b10,1, 0,0, "R7 timeout with data");
        step(0,1,1, 5'd0, 5'd2, 2'b10,0, 0,0, "R8 hold after timeout");
        step(0,1,1, 5'd0, 5'd0, 2'b10,1, 0,1, "R7 timeout with empty fifo");
        // other trigger encodings
        step(0,1,1, 5'd0,5'd13, 2'b11,0, 0,1, "R6 below trigger 14");
        step(0,1,1, 5'd0,5'd14, 2'b11,0, 0,0, "R6 at trigger 14");
        step(0,1,1, 5'd0, 5'd0, 2'b11,0, 0,1, "R8 empty");
        step(0,1,1, 5'd0, 5'd1, 2'b00,0, 0,0, "R6 at trigger 1");
        step(0,1,1, 5'd0, 5'd0, 2'b00,0, 0,1, "R8 empty");
        step(0,1,1, 5'd0, 5'd3, 2'b01,0, 0,1, "R6 below trigger 4");
        step(0,1,1, 5'd0, 5'd4, 2'b01,0, 0,0, "R6 at trigger 4");
        step(0,1,1, 5'd0, 5'd0, 2'b01,0, 0,1, "R8 empty");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule